// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects a clocked request/acknowledge port inside the chip to an external asynchronous static RAM. The RAM holds 64K words of 16 bits and has separate lower and upper byte lanes. Each request carries an address, write data, a two-bit byte mask and a read/write flag. The controller then runs one complete cycle on the memory pins and answers with a single-cycle acknowledge. For a read, the acknowledge comes with the registered read data.

The memory pins are active-low chip enable, write enable, output enable, and one select per byte lane. The address bus is registered and changes only while the memory is deselected. The data bus is split into an output value, an output enable and an input value, so the pad ring can build the tri-state buffer. All timing windows are parameters counted in clock cycles:

- the data lead before the write strobe falls,
- the width of the write strobe,
- the read access time,
- the bus turnaround.

A write that follows a read always passes through a turnaround phase. During that phase the controller does not drive the bus, so the memory outputs have time to float.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are 1, and mem_dq_oe and req_ack are 0.
- R2: During a write, the sequence on the pins is as follows.
  - mem_ce_n is low and the data is driven for SETUP_CYC cycles with mem_we_n high.
  - mem_we_n is then low for exactly PULSE_CYC cycles.
  - The data stays driven and mem_ce_n stays low for one cycle after mem_we_n rises.
  - The acknowledge follows. With no turnaround, req_ack is seen SETUP_CYC+PULSE_CYC+2 clock edges after the request is presented.
- R3: While mem_ce_n is low, mem_lb_n equals the inverse of req_mask bit 0 and mem_ub_n equals the inverse of req_mask bit 1. Bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A write with mask 00 leaves memory unchanged.
- R4: During a read, mem_ce_n and mem_oe_n are low and mem_we_n is high for READ_CYC cycles. The value on mem_dq_i is captured on the last of these cycles. req_ack is seen READ_CYC+1 edges after the request, with rd_data already valid.
- R5: In rd_data, the byte lanes whose mask bit is 0 read as zero.
- R6: req_ack lasts one cycle. A request still held high during the acknowledge cycle does not start a second access.
- R7: mem_addr stays stable while mem_ce_n is low. It takes the new request address only while the memory is deselected.
- R8: A write that follows a read first spends TURN_CYC cycles with mem_ce_n, mem_oe_n and mem_we_n high and the bus not driven. In that case req_ack is seen TURN_CYC+SETUP_CYC+PULSE_CYC+2 edges after the request.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, and never while the memory outputs may still be active.
- R10: A write that follows a write skips the turnaround phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane enables, bit 0 = low byte, bit 1 = high byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, lanes outside the mask zeroed |
| mem_addr | output | AW | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte lane select, active low |
| mem_ub_n | output | 1 | High byte lane select, active low |
| mem_dq_o | output | 16 | Data to the pad driver |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 16 | Data from the pad receiver |

## Verification
Two events can land in the same cycle:

- **Acknowledge and held request.** The acknowledge of one access meets a request that is still held high. This is provoked by keeping req_valid asserted through the acknowledge cycle. It is judged by counting chip-enable falls and acknowledges afterwards: exactly one each is expected.
- **Read end and write start.** The end of a read meets a write that follows at once. The memory model keeps driving for a cycle after output enable rises. The bench flags any cycle in which the controller drives the bus while that model is still active. It also checks that the write latency includes the turnaround.

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl #(
  parameter int AW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int READ_CYC  = 3,
  parameter int TURN_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          req_ack,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);

  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2 = (READ_CYC > TURN_CYC) ? READ_CYC : TURN_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    IDLE, SETUP, WRITE_PULSE, WRITE_RECOVER, READ_ACCESS, TURNAROUND
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          rd_last;
  logic [15:0]   wd_q;
  logic [1:0]    msk_q;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      rd_last  <= 1'b0;
      wd_q     <= '0;
      msk_q    <= '0;
      mem_addr <= '0;
      rd_data  <= '0;
      req_ack  <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      case (st)
        IDLE:
          if (req_valid && !req_ack) begin
            mem_addr <= req_addr;
            wd_q     <= req_wdata;
            msk_q    <= req_mask;
            if (!req_write) begin
              st  <= READ_ACCESS;
              cnt <= CW'(READ_CYC - 1);
            end else if (rd_last) begin
              st  <= TURNAROUND;
              cnt <= CW'(TURN_CYC - 1);
            end else begin
              st  <= SETUP;
              cnt <= CW'(SETUP_CYC - 1);
            end
          end
        TURNAROUND:
          if (last) begin
            st      <= SETUP;
            cnt     <= CW'(SETUP_CYC - 1);
            rd_last <= 1'b0;
          end else cnt <= cnt - 1'b1;
        SETUP:
          if (last) begin
            st  <= WRITE_PULSE;
            cnt <= CW'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        WRITE_PULSE:
          if (last) st <= WRITE_RECOVER;
          else      cnt <= cnt - 1'b1;
        WRITE_RECOVER: begin
          st      <= IDLE;
          req_ack <= 1'b1;
        end
        READ_ACCESS:
          if (last) begin
            rd_data <= mem_dq_i & {{8{msk_q[1]}}, {8{msk_q[0]}}};
            req_ack <= 1'b1;
            rd_last <= 1'b1;
            st      <= IDLE;
          end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assign mem_ce_n  = (st == IDLE) || (st == TURNAROUND);
  assign mem_we_n  = (st != WRITE_PULSE);
  assign mem_oe_n  = (st != READ_ACCESS);
  assign mem_dq_oe = (st == SETUP) || (st == WRITE_PULSE) || (st == WRITE_RECOVER);
  assign mem_dq_o  = wd_q;
  assign mem_lb_n  = mem_ce_n || !msk_q[0];
  assign mem_ub_n  = mem_ce_n || !msk_q[1];

  // R9
  no_drive_while_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R2
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R4
  read_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  // R8
  drive_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

endmodule

// File: tb/sim_sram_port_ctrl.sv
`timescale 1ns/1ps
module sim_sram_port_ctrl;
  localparam int S = 1, W = 2, R = 3, T = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ack;
  logic [15:0] rd_data, mem_addr, mem_dq_o, mem_dq_i;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

  always #2.5 clk = ~clk;

  sram_port_ctrl #(.AW(16), .SETUP_CYC(S), .PULSE_CYC(W), .READ_CYC(R), .TURN_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ack(req_ack), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: drives while selected for read, keeps driving one cycle after release
  logic [15:0] mem [256];
  logic mem_drive, drive_lag = 1'b0;
  assign mem_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = mem_drive ? {mem_ub_n ? 8'hA5 : mem[mem_addr[7:0]][15:8],
                                 mem_lb_n ? 8'hA5 : mem[mem_addr[7:0]][7:0]} : 16'h5A5A;
  always @(posedge clk) drive_lag <= mem_drive;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      check(mem_dq_oe, "R2 data held at commit", {31'd0, mem_dq_oe}, 1);
      if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n) mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
    end
  end

  logic [15:0] cur_addr = '0;
  logic [1:0]  cur_mask = '0;
  int we_lo = 0, ce_falls = 0, acks = 0;
  logic prev_ce = 1'b1;

  always @(negedge clk) if (rst_n && !done) begin
    if (!mem_ce_n) begin
      check(mem_lb_n == !cur_mask[0] && mem_ub_n == !cur_mask[1], "R3 lane selects",
            {30'd0, mem_ub_n, mem_lb_n}, {30'd0, ~cur_mask});
      check(mem_addr == cur_addr, "R7 address", mem_addr, cur_addr);
    end
    if (mem_dq_oe)
      check(!mem_drive && !drive_lag, "R9 bus contention", {30'd0, mem_drive, drive_lag}, 0);
    if (!mem_we_n) we_lo++;
    else if (we_lo != 0) begin
      check(we_lo == W, "R2 pulse width", we_lo, W);
      we_lo = 0;
    end
    if (prev_ce && !mem_ce_n) ce_falls++;
    prev_ce = mem_ce_n;
    if (req_ack) acks++;
  end

  task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rdv, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr = a; cur_mask = m;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ack && lat < 100);
    rdv = rd_data;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  // {write, addr, data, mask}
  localparam logic [34:0] VEC [10] = '{
    {1'b1, 16'h0012, 16'hBEEF, 2'b11},
    {1'b0, 16'h0012, 16'h0000, 2'b11},
    {1'b1, 16'h0034, 16'h1234, 2'b01},
    {1'b0, 16'h0034, 16'h0000, 2'b11},
    {1'b1, 16'h0034, 16'hAB00, 2'b10},
    {1'b0, 16'h0034, 16'h0000, 2'b10},
    {1'b0, 16'h0034, 16'h0000, 2'b01},
    {1'b1, 16'h1256, 16'hCAFE, 2'b11},
    {1'b1, 16'h1256, 16'h0F0F, 2'b00},
    {1'b0, 16'h1256, 16'h0000, 2'b11}
  };

  logic [15:0] shadow [256];

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rdv;
    int lat, exp_lat, f0, a0;
    bit prev_rd;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111 && !mem_dq_oe && !req_ack,
          "R1 reset pins", {25'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, req_ack},
          32'h7C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    prev_rd = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic wr; logic [15:0] a, d; logic [1:0] m; logic [15:0] lm;
      {wr, a, d, m} = VEC[i];
      lm = {{8{m[1]}}, {8{m[0]}}};
      if (wr) exp_lat = (prev_rd ? T : 0) + S + W + 2;
      else    exp_lat = R + 1;
      do_req(wr, a, d, m, rdv, lat);
      if (wr) begin
        check(lat == exp_lat, prev_rd ? "R8 write after read latency" : "R10 R2 write latency", lat, exp_lat);
        shadow[a[7:0]] = (shadow[a[7:0]] & ~lm) | (d & lm);
      end else begin
        check(lat == exp_lat, "R4 read latency", lat, exp_lat);
        check(rdv == (shadow[a[7:0]] & lm), "R4 R5 read data", rdv, shadow[a[7:0]] & lm);
      end
      prev_rd = !wr;
    end

    // R1 idle after traffic
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 5'b11111 && !mem_dq_oe,
          "R1 idle pins", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 32'h3E);

    // R6: request held through the acknowledge cycle
    f0 = ce_falls; a0 = acks;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0012; req_mask = 2'b11;
    cur_addr = 16'h0012; cur_mask = 2'b11;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ack && lat < 100);
    check(rd_data == 16'hBEEF, "R4 held read data", rd_data, 16'hBEEF);
    @(negedge clk);
    check(!req_ack, "R6 ack one cycle", {31'd0, req_ack}, 0);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(ce_falls - f0 == 1, "R6 single access", ce_falls - f0, 1);
    check(acks - a0 == 1, "R6 single ack", acks - a0, 1);

    // R8 again back to back: read then immediate write, then verify
    do_req(1'b0, 16'h0034, 16'h0, 2'b11, rdv, lat);
    do_req(1'b1, 16'h0077, 16'h5566, 2'b11, rdv, lat);
    check(lat == T + S + W + 2, "R8 turnaround latency", lat, T + S + W + 2);
    do_req(1'b0, 16'h0077, 16'h0, 2'b11, rdv, lat);
    check(rdv == 16'h5566, "R2 write reached memory", rdv, 16'h5566);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule